// File: doc/BRIEF.md
# Serial EEPROM Slave

This block models the slave side of a byte-wide serial EEPROM reached over a four-wire serial bus. All bus lines are sampled on a fast system clock. The block finds rising edges of the serial clock itself, shifts in an 8-bit instruction and a 16-bit address MSB first, and then either stores received bytes into an internal array or returns array or status bytes on a single data-out line.

Array writes pass two gates. The first is a write-enable latch that software sets and clears with dedicated instructions. The second is a two-bit block-protect field in the status register that locks the upper quarter, the upper half or the whole of the 64 KB address space. Sequential writes stay inside a 128-byte page. Sequential reads run across the whole address space. The physical array holds `MEM_DEPTH` bytes and is indexed by the low address bits.

A side port, intended for test, preloads and inspects the array without using the serial bus.

Top module: `serial_eeprom_slave`

## Requirements
- R1: The control word carries data-in at bit 0, serial clock at bit 1, active-low hold at bit 2 and active-low select at bit 3. After reset, data-out is 1 and the status register is 0x00.
- R2: While select is high (with hold high), data-out becomes 1 on the next clock, and the bit counter and instruction are cleared. A command cut off part-way leaves the next command correctly aligned.
- R3: While hold is low, nothing is processed and data-out does not change, whatever the serial clock does.
- R4: Instruction 0x06 sets status bit 1 (the write-enable latch) and 0x04 clears it. 0x05 returns the status byte. 0x01 loads status bits 3:2 from the next byte, keeps bit 1, and clears every other bit.
- R5: Instruction 0x03 followed by a 16-bit address returns array bytes MSB first, one bit per serial clock rising edge. Data-out changes only on such an edge or on deselect.
- R6: Each completed read byte advances the address modulo 65536, so a read from 0xFFFF continues at 0x0000.
- R7: Instruction 0x02 followed by an address stores each received byte only while the write-enable latch is 1.
- R8: With block-protect bits 3:2 at 01, writes at 0xC000 and above are dropped. At 10, writes at 0x8000 and above are dropped. At 11, all array writes are dropped.
- R9: After each written byte, only the low 7 address bits increment and wrap (0x7F goes to 0x00). The upper bits are kept.
- R10: The write-enable latch falls only on instruction 0x04 or reset, never as a side effect of an array or status write.
- R11: Any other instruction value parks the slave: data-out stays 1 and further clocks are ignored until deselect.
- R12: A status read keeps returning the status byte for every further 8 clocks.
- R13: The array byte at 16-bit address A sits at index A mod `MEM_DEPTH`. The side port writes in one clock and returns read data one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrlIn | input | 4 | Packed bus lines: {select_n, hold_n, serial clock, data-in} |
| sdo | output | 1 | Serial data-out |
| bdWe | input | 1 | Side-port write strobe |
| bdAddr | input | IDX_W | Side-port array index |
| bdWdata | input | 8 | Side-port write data |
| bdRdata | output | 8 | Side-port read data, registered |

## Verification
Reads are tried at a plain low address, across the 0xFFFF top of the space and as repeated status bytes. These cases separate full-space wrapping from page wrapping and array reloads from status reloads. Writes are tried with the latch clear, with the latch set, across a page end and under each block-protect code on both sides of its boundary, which separates the latch gate from each region comparison. Hold pulses with serial clock activity, a part-sent instruction, an unknown instruction and a read aborted mid-byte each show that the frozen, parked and reset paths leave the next command intact.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int OP_W   = 8;
  localparam int ADR_W  = 16;
  localparam int PAGE_W = 7;
  localparam int CNT_W  = 5;

  localparam logic [OP_W-1:0] OP_STATUS_WR = 8'h01;
  localparam logic [OP_W-1:0] OP_ARRAY_WR  = 8'h02;
  localparam logic [OP_W-1:0] OP_ARRAY_RD  = 8'h03;
  localparam logic [OP_W-1:0] OP_LATCH_CLR = 8'h04;
  localparam logic [OP_W-1:0] OP_STATUS_RD = 8'h05;
  localparam logic [OP_W-1:0] OP_LATCH_SET = 8'h06;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_ADDR, ST_WRITE, ST_READ, ST_PARK
  } spiState_e;

  typedef struct packed {
    logic deselect;
    logic addrShift;
    logic dataShift;
    logic arrayCommit;
    logic statusCommit;
    logic latchSet;
    logic latchClr;
    logic loadStatus;
    logic loadArray;
    logic nextAddr;
    logic outShift;
  } strobe_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    selN,
  input  logic    holdN,
  input  logic    sclk,
  input  logic    din,
  output strobe_t strb
);
  spiState_e state, nState;
  logic [CNT_W-1:0] bitCnt, nCnt;
  logic [OP_W-1:0]  opcode, nOp;
  logic prevSclk;
  logic rise;
  logic [OP_W-1:0] fullOp;

  assign rise   = sclk & ~prevSclk;
  assign fullOp = {opcode[OP_W-2:0], din};

  always_comb begin
    strb   = '0;
    nState = state;
    nCnt   = bitCnt;
    nOp    = opcode;
    if (holdN) begin
      if (selN) begin
        strb.deselect = 1'b1;
        nState = ST_OPCODE;
        nCnt   = '0;
        nOp    = '0;
      end else if (rise) begin
        unique case (state)
          ST_OPCODE: begin
            nOp  = fullOp;
            nCnt = bitCnt + 1'b1;
            if (bitCnt == CNT_W'(OP_W - 1)) begin
              nCnt = '0;
              case (fullOp)
                OP_STATUS_WR: nState = ST_WRITE;
                OP_ARRAY_WR, OP_ARRAY_RD: nState = ST_ADDR;
                OP_LATCH_CLR: begin strb.latchClr = 1'b1; nState = ST_PARK; end
                OP_LATCH_SET: begin strb.latchSet = 1'b1; nState = ST_PARK; end
                OP_STATUS_RD: begin strb.loadStatus = 1'b1; nState = ST_READ; end
                default: nState = ST_PARK;
              endcase
            end
          end
          ST_ADDR: begin
            strb.addrShift = 1'b1;
            nCnt = bitCnt + 1'b1;
            if (bitCnt == CNT_W'(ADR_W - 1)) begin
              nCnt = '0;
              if (opcode[0]) begin
                strb.loadArray = 1'b1;
                nState = ST_READ;
              end else begin
                nState = ST_WRITE;
              end
            end
          end
          ST_WRITE: begin
            strb.dataShift = 1'b1;
            nCnt = bitCnt + 1'b1;
            if (bitCnt == CNT_W'(OP_W - 1)) begin
              nCnt = '0;
              if (opcode == OP_STATUS_WR) begin
                strb.statusCommit = 1'b1;
                nState = ST_PARK;
              end else begin
                strb.arrayCommit = 1'b1;
              end
            end
          end
          ST_READ: begin
            strb.outShift = 1'b1;
            nCnt = bitCnt + 1'b1;
            if (bitCnt == CNT_W'(OP_W - 1)) begin
              nCnt = '0;
              if (opcode == OP_ARRAY_RD) strb.nextAddr = 1'b1;
              else                       strb.loadStatus = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OPCODE;
      bitCnt   <= '0;
      opcode   <= '0;
      prevSclk <= 1'b0;
    end else begin
      state    <= nState;
      bitCnt   <= nCnt;
      opcode   <= nOp;
      prevSclk <= sclk;
    end
  end
endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int MEM_DEPTH = 2048,
  localparam int IDX_W = $clog2(MEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  strobe_t          strb,
  input  logic             bdWe,
  input  logic [IDX_W-1:0] bdAddr,
  input  logic [7:0]       bdWdata,
  output logic [7:0]       bdRdata,
  output logic             sdo,
  output logic [7:0]       statusQ,
  output logic             arrayWe
);
  logic [ADR_W-1:0] addrQ;
  logic [7:0] dataSh, outBuf, ramQ, rxByte;
  logic [1:0] ldPipe;
  logic blocked;
  logic [7:0] mem [MEM_DEPTH];

  assign rxByte = {dataSh[6:0], din};

  always_comb begin
    unique case (statusQ[3:2])
      2'b00: blocked = 1'b0;
      2'b01: blocked = addrQ >= 16'hC000;
      2'b10: blocked = addrQ >= 16'h8000;
      default: blocked = 1'b1;
    endcase
  end

  assign arrayWe = strb.arrayCommit & statusQ[1] & ~blocked;

  always_ff @(posedge clk) begin
    if (arrayWe) mem[addrQ[IDX_W-1:0]] <= rxByte;
    if (bdWe)    mem[bdAddr] <= bdWdata;
    ramQ    <= mem[addrQ[IDX_W-1:0]];
    bdRdata <= mem[bdAddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      dataSh  <= '0;
      statusQ <= '0;
      outBuf  <= '0;
      sdo     <= 1'b1;
      ldPipe  <= '0;
    end else begin
      ldPipe <= {ldPipe[0], strb.loadArray | strb.nextAddr};
      if (strb.addrShift)   addrQ <= {addrQ[ADR_W-2:0], din};
      if (strb.nextAddr)    addrQ <= addrQ + 1'b1;
      if (strb.arrayCommit) addrQ <= {addrQ[ADR_W-1:PAGE_W], addrQ[PAGE_W-1:0] + 1'b1};
      if (strb.dataShift)   dataSh <= rxByte;
      if (strb.latchSet)    statusQ[1] <= 1'b1;
      if (strb.latchClr)    statusQ[1] <= 1'b0;
      if (strb.statusCommit) statusQ <= {4'b0, rxByte[3:2], statusQ[1], 1'b0};
      if (strb.deselect)     sdo <= 1'b1;
      else if (strb.outShift) sdo <= outBuf[7];
      if (strb.outShift)   outBuf <= {outBuf[6:0], 1'b0};
      if (strb.loadStatus) outBuf <= statusQ;
      if (ldPipe[1])       outBuf <= ramQ;
    end
  end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_DEPTH = 2048,
  localparam int IDX_W = $clog2(MEM_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       ctrlIn,
  output logic             sdo,
  input  logic             bdWe,
  input  logic [IDX_W-1:0] bdAddr,
  input  logic [7:0]       bdWdata,
  output logic [7:0]       bdRdata
);
  strobe_t strb;
  logic [7:0] statusQ;
  logic arrayWe;

  eeprom_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .selN(ctrlIn[3]), .holdN(ctrlIn[2]), .sclk(ctrlIn[1]), .din(ctrlIn[0]),
    .strb(strb)
  );

  eeprom_datapath #(.MEM_DEPTH(MEM_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .din(ctrlIn[0]), .strb(strb),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdWdata(bdWdata), .bdRdata(bdRdata),
    .sdo(sdo), .statusQ(statusQ), .arrayWe(arrayWe)
  );
endmodule

// File: rtl/serial_eeprom_checker.sv
module serial_eeprom_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] ctrlIn,
  input logic       sdo,
  input logic [3:1] statusBits,
  input logic       arrayWe,
  input logic       latchSet,
  input logic       latchClr,
  input logic       outShift
);
  a_r1_reset_out: assert property (@(posedge clk) rst |=> sdo);

  a_r2_deselect_out: assert property (@(posedge clk) disable iff (rst)
    (ctrlIn[3] && ctrlIn[2]) |=> sdo);

  a_r3_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    !ctrlIn[2] |=> $stable(sdo));

  a_r4_latch_set: assert property (@(posedge clk) disable iff (rst)
    latchSet |=> statusBits[1]);

  a_r5_out_on_edge: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $past(ctrlIn[3] | outShift));

  a_r7_write_gate: assert property (@(posedge clk) disable iff (rst)
    arrayWe |-> statusBits[1]);

  a_r8_full_protect: assert property (@(posedge clk) disable iff (rst)
    arrayWe |-> (statusBits[3:2] != 2'b11));

  a_r10_latch_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(statusBits[1]) |-> $past(latchClr));
endmodule

bind serial_eeprom_slave serial_eeprom_checker u_chk (
  .clk(clk), .rst(rst), .ctrlIn(ctrlIn), .sdo(sdo),
  .statusBits(statusQ[3:1]), .arrayWe(arrayWe),
  .latchSet(strb.latchSet), .latchClr(strb.latchClr), .outShift(strb.outShift)
);

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
  localparam int DEPTH = 2048;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic selN = 1'b1, holdN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic bdWe = 1'b0;
  logic [IW-1:0] bdAddr = '0;
  logic [7:0] bdWdata = '0;
  wire  [7:0] bdRdata;
  wire        sdo;
  wire  [3:0] ctrlIn = {selN, holdN, sclk, din};

  serial_eeprom_slave #(.MEM_DEPTH(DEPTH)) i_serial_eeprom_slave (
    .clk(clk), .rst(rst), .ctrlIn(ctrlIn), .sdo(sdo),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdWdata(bdWdata), .bdRdata(bdRdata)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] expVal[$];
  string      expTag[$];
  event sampleEv;
  logic capEn = 1'b0;
  logic [7:0] monSh = '0, monGot, monExp;
  int monCnt = 0;
  string monTag;

  // scoreboard monitor: assembles received bytes and compares with queue
  always @(sampleEv) begin
    monGot = {monSh[6:0], sdo};
    monSh  = monGot;
    monCnt++;
    if (monCnt == 8) begin
      monCnt = 0;
      checks++;
      if (expVal.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected byte actual=%h expected=none", monGot);
      end else begin
        monExp = expVal.pop_front();
        monTag = expTag.pop_front();
        if (monGot !== monExp) begin
          errors++;
          $display("FAIL %s read byte actual=%h expected=%h", monTag, monGot, monExp);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitOut(input logic b);
    din = b; sclk = 1'b0; tick(2);
    sclk = 1'b1; tick(2);
    if (capEn) begin #5; ->sampleEv; end
    tick(1);
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
  endtask

  task automatic select();
    selN = 1'b0; sclk = 1'b0; tick(2);
  endtask

  task automatic deselect();
    sclk = 1'b0; selN = 1'b1; tick(3);
  endtask

  task automatic expectByte(input logic [7:0] v, input string t);
    expVal.push_back(v); expTag.push_back(t);
  endtask

  task automatic readInto(input int n);
    capEn = 1'b1;
    repeat (n * 8) bitOut(1'b0);
    capEn = 1'b0;
  endtask

  task automatic readStatus(input logic [7:0] v, input string t, input int n);
    select(); sendByte(8'h05);
    for (int i = 0; i < n; i++) expectByte(v, t);
    readInto(n); deselect();
  endtask

  task automatic simpleCmd(input logic [7:0] op);
    select(); sendByte(op); deselect();
  endtask

  task automatic writeStatus(input logic [7:0] v);
    select(); sendByte(8'h01); sendByte(v); deselect();
  endtask

  task automatic writeOne(input logic [15:0] a, input logic [7:0] d);
    select(); sendByte(8'h02); sendByte(a[15:8]); sendByte(a[7:0]);
    sendByte(d); deselect();
  endtask

  task automatic bdWrite(input int a, input logic [7:0] v);
    bdAddr = IW'(a); bdWdata = v; bdWe = 1'b1; tick(1); bdWe = 1'b0;
  endtask

  task automatic bdCheck(input logic [15:0] a, input string t);
    bdAddr = a[IW-1:0]; tick(2);
    chk(bdRdata, model[a[IW-1:0]], t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(4); rst = 1'b0; tick(2);
    chk({7'b0, sdo}, 8'h01, "R1 reset data-out");
    readStatus(8'h00, "R1 reset status", 1);

    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'(i * 13 + 5);
      bdWrite(i, model[i]);
    end
    model[12'h030] = 8'h00; bdWrite(12'h030, 8'h00);
    bdCheck(16'h0005, "R13 side port");

    // R5 plain read, sequential
    select(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h10);
    for (int i = 0; i < 3; i++) expectByte(model[16 + i], "R5 array read");
    readInto(3); deselect();

    // R7 write with latch clear is dropped
    writeOne(16'h0020, 8'hA5);
    bdCheck(16'h0020, "R7 write without latch");

    // R4 latch set, R7 write accepted
    simpleCmd(8'h06);
    readStatus(8'h02, "R4 latch set", 1);
    select(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h20);
    sendByte(8'hA5); sendByte(8'h5A); deselect();
    model[12'h020] = 8'hA5; model[12'h021] = 8'h5A;
    bdCheck(16'h0020, "R7 write with latch");
    bdCheck(16'h0021, "R7 second byte");
    readStatus(8'h02, "R10 latch kept after array write", 1);

    // R9 page wrap
    select(); sendByte(8'h02); sendByte(8'h00); sendByte(8'h7F);
    sendByte(8'h11); sendByte(8'h22); deselect();
    model[12'h07F] = 8'h11; model[12'h000] = 8'h22;
    bdCheck(16'h007F, "R9 page end");
    bdCheck(16'h0000, "R9 page wrap");
    bdCheck(16'h0080, "R9 next page untouched");

    // R4/R12 status write 0xFF -> 0x0E, repeated
    writeStatus(8'hFF);
    readStatus(8'h0E, "R12 status repeat", 2);
    writeOne(16'h0100, 8'h77);
    bdCheck(16'h0100, "R8 full protect");

    // R8 upper quarter
    writeStatus(8'h04);
    readStatus(8'h06, "R4 status write keeps latch", 1);
    writeOne(16'hC005, 8'h99);
    bdCheck(16'hC005, "R8 quarter blocked");
    writeOne(16'hBFFF, 8'h3C); model[12'h7FF] = 8'h3C;
    bdCheck(16'hBFFF, "R8 below quarter");

    // R8 upper half
    writeStatus(8'h08);
    writeOne(16'h8003, 8'h44);
    bdCheck(16'h8003, "R8 half blocked");
    writeOne(16'h7FF0, 8'h66); model[12'h7F0] = 8'h66;
    bdCheck(16'h7FF0, "R8 below half");

    // R4 latch clear
    simpleCmd(8'h04);
    readStatus(8'h08, "R4 latch clear", 1);

    // R6 read wrap across top of space
    select(); sendByte(8'h03); sendByte(8'hFF); sendByte(8'hFF);
    expectByte(model[12'h7FF], "R6 top byte");
    expectByte(model[12'h000], "R6 wrapped byte");
    readInto(2); deselect();

    // R3 hold freezes mid status read (0x08: fifth bit is 1)
    select(); sendByte(8'h05);
    expectByte(8'h08, "R3 byte across hold");
    capEn = 1'b1; repeat (4) bitOut(1'b0); capEn = 1'b0;
    holdN = 1'b0;
    repeat (3) begin sclk = 1'b1; tick(3); sclk = 1'b0; tick(3); end
    chk({7'b0, sdo}, 8'h00, "R3 hold freeze");
    holdN = 1'b1; tick(2);
    capEn = 1'b1; repeat (4) bitOut(1'b0); capEn = 1'b0;
    deselect();

    // R11 unknown instruction parks the slave
    select(); sendByte(8'h9F);
    repeat (8) bitOut(1'b0);
    chk({7'b0, sdo}, 8'h01, "R11 parked data-out");
    deselect();
    readStatus(8'h08, "R11 recovers after deselect", 1);

    // R2 abort mid-instruction
    select(); repeat (4) bitOut(1'b0); deselect();
    readStatus(8'h08, "R2 aligned after abort", 1);

    // R2 abort mid-read forces data-out high
    select(); sendByte(8'h03); sendByte(8'h00); sendByte(8'h30);
    bitOut(1'b0);
    chk({7'b0, sdo}, 8'h00, "R5 first bit of zero byte");
    deselect();
    chk({7'b0, sdo}, 8'h01, "R2 deselect data-out");

    tick(5);
    chk(8'(expVal.size()), 8'h00, "R5 all expected bytes received");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule